// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

This block is a down-counting interrupt timer advanced by a bus-clock tick enable. Software loads an initial count through a 32-bit register port. The timer then counts the period down through a programmable power-of-two prescaler. When the period runs out it either stops (one-shot) or reloads itself (periodic).

Expiries are not delivered directly. Each one adds to a small pending counter, and a request/accept interface drains that counter one accepted delivery at a time. The block also holds six interrupt vector-table entries. The first entry controls the timer. All six are masked together when the software enable is cleared.

The register map uses a 4-bit word address. Reads are combinational on the address, and writes take effect at the clock edge on which `regWr` is high.

Top module: `lt_timer`

## Requirements
- R1: The divide code is {cfg[3], cfg[1], cfg[0]} of a write to address 3, and the divisor is 1 << ((code + 1) mod 8): code 7 (cfg 0xB) gives 1, code 0 gives 2, code 3 gives 16. Address 3 reads back only bits 3, 1 and 0.
- R2: A write to address 1 stores the initial count, discards any running count, zeroes the pending counter and restarts the period. The first expiry then comes after exactly initial count × divisor ticks. A tick in the same cycle as the write is not counted.
- R3: With an initial count of zero the timer does not run: address 2 reads 0 and no expiry occurs, whatever the ticks.
- R4: Address 2 reads floor(remaining ticks / divisor), and it reads 0 after a one-shot period has ended.
- R5: Bit 17 of the timer entry (address 8) selects periodic mode, in which each expiry reloads the full period. With bit 17 clear the timer stops after one expiry.
- R6: Each expiry adds one to a pending counter that saturates at 2^PEND_W − 1. `delivReq` is high when the counter is nonzero, timer-entry mask bit 16 is clear, software enable (address 0 bit 0) is set and `hwEnable` is high. The counter drops by one only in a cycle where `delivReq` and `delivAck` are both high. An expiry and an accepted delivery in the same cycle leave the counter unchanged.
- R7: Writing 0 to address 0 bit 0 sets mask bit 16 in all six entries (addresses 8 to 13) and zeroes the pending counter. While software enable is off, every entry write stores bit 16 as 1.
- R8: The timer entry keeps only bits 7:0 (vector), 12 (delivery status), 16 (mask) and 17 (periodic). The other five entries keep only bits 7:0 and 16. `delivVector` is the timer entry's bits 7:0.
- R9: A write to address 3 restarts the prescaler from zero and leaves the count itself unchanged. The remaining time becomes the current count rounded up, times the new divisor. A tick in that cycle is not counted.
- R10: After reset every entry reads 0x0001_0000, and addresses 0, 1, 2 and 3 read 0. Writes to address 2 are ignored, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busTick | input | 1 | One bus-clock tick per high cycle |
| hwEnable | input | 1 | Global enable for delivery |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| delivReq | output | 1 | Delivery request for the timer interrupt |
| delivVector | output | 8 | Vector of the timer interrupt |
| delivAck | input | 1 | Delivery accepted this cycle |

## Verification
The bench builds the block with CNT_W = 32 and PEND_W = 3. The narrow pending counter lets a periodic one-tick period with divisor 1 reach saturation at 7 within about twenty ticks, so the saturated drain sequence is checked directly. The full 32-bit count keeps all eight divisors and count × divisor products exact in the reference model. A long stretch of random ticks, acknowledges and enable toggles then exercises periodic reload against pending-counter arithmetic, including an expiry and an accepted delivery in the same cycle.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef struct packed {
    logic loadInit;    // start a new period from the written value
    logic restartPre;  // prescaler back to zero
    logic clearPend;   // drop all pending expiries
    logic popPend;     // one delivery accepted
  } ltStrobes_t;

  localparam int NUM_ENTRIES = 6;
  localparam int MASK_BIT = 16;
  localparam int PERIODIC_BIT = 17;

  localparam logic [3:0] ADDR_CTRL   = 4'h0;
  localparam logic [3:0] ADDR_INIT   = 4'h1;
  localparam logic [3:0] ADDR_CUR    = 4'h2;
  localparam logic [3:0] ADDR_DIV    = 4'h3;
  localparam logic [3:0] ADDR_ENTRY0 = 4'h8;

  localparam logic [31:0] TIMER_KEEP = 32'h0003_10FF;
  localparam logic [31:0] OTHER_KEEP = 32'h0001_00FF;
  localparam logic [31:0] MASK_ONLY  = 32'h0001_0000;

endpackage

// File: rtl/lt_ctrl.sv
module lt_ctrl
  import lt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [3:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [CNT_W-1:0] curRead,
  input  logic             pendNonZero,
  input  logic             hwEnable,
  input  logic             delivAck,
  output ltStrobes_t       strb,
  output logic [CNT_W-1:0] initVal,
  output logic [2:0]       divShift,
  output logic             periodic,
  output logic             delivReq,
  output logic [7:0]       delivVector
);

  logic [31:0] entryReg [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] maskVec;
  logic swEn;
  logic [2:0] divCode;
  logic swOffWr;

  assign swOffWr = regWr && (regAddr == ADDR_CTRL) && !regWdata[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swEn    <= 1'b0;
      initVal <= '0;
      divCode <= 3'd0;
    end else if (regWr) begin
      if (regAddr == ADDR_CTRL) swEn <= regWdata[0];
      if (regAddr == ADDR_INIT) initVal <= regWdata[CNT_W-1:0];
      if (regAddr == ADDR_DIV) divCode <= {regWdata[3], regWdata[1], regWdata[0]};
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEntry
    localparam logic [31:0] KEEP = (i == 0) ? TIMER_KEEP : OTHER_KEEP;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryReg[i] <= MASK_ONLY;
      end else if (swOffWr) begin
        entryReg[i] <= entryReg[i] | MASK_ONLY;
      end else if (regWr && (regAddr == ADDR_ENTRY0 + 4'(i))) begin
        entryReg[i] <= (regWdata & KEEP) | (swEn ? 32'h0 : MASK_ONLY);
      end
    end
    assign maskVec[i] = entryReg[i][MASK_BIT];
  end

  assign divShift    = divCode + 3'd1;
  assign periodic    = entryReg[0][PERIODIC_BIT];
  assign delivVector = entryReg[0][7:0];
  assign delivReq    = pendNonZero && !maskVec[0] && swEn && hwEnable;

  always_comb begin
    strb.loadInit   = regWr && (regAddr == ADDR_INIT);
    strb.restartPre = regWr && ((regAddr == ADDR_INIT) || (regAddr == ADDR_DIV));
    strb.clearPend  = strb.loadInit || swOffWr;
    strb.popPend    = delivReq && delivAck;
  end

  always_comb begin
    regRdata = 32'h0;
    case (regAddr)
      ADDR_CTRL: regRdata = {31'h0, swEn};
      ADDR_INIT: regRdata = 32'(initVal);
      ADDR_CUR:  regRdata = 32'(curRead);
      ADDR_DIV:  regRdata = {28'h0, divCode[2], 1'b0, divCode[1:0]};
      default: begin
        for (int i = 0; i < NUM_ENTRIES; i++)
          if (regAddr == ADDR_ENTRY0 + 4'(i)) regRdata = entryReg[i];
      end
    endcase
  end

  // R7: with software enable off, every entry stays masked
  assert_masked_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !swEn |-> (&maskVec));

  // R8: a timer-entry write never leaves bits outside the kept fields
  assert_timer_fields_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_ENTRY0) |=> ((entryReg[0] & ~TIMER_KEEP) == 32'h0));

endmodule

// File: rtl/lt_datapath.sv
module lt_datapath
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busTick,
  input  ltStrobes_t       strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [2:0]       divShift,
  input  logic             periodic,
  output logic [CNT_W-1:0] curRead,
  output logic             pendNonZero
);

  localparam int PRE_W = 7;
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [CNT_W-1:0]  cnt;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  divLast;
  logic [PRE_W:0]    divOne;
  logic [PEND_W-1:0] pendCnt;
  logic preWrap;
  logic expire;

  assign divOne  = (PRE_W+1)'(1) << divShift;
  assign divLast = PRE_W'(divOne - (PRE_W+1)'(1));
  assign preWrap = (preCnt == divLast);
  assign expire  = !strb.restartPre && busTick && (cnt == CNT_W'(1)) && preWrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      preCnt <= '0;
    end else if (strb.loadInit) begin
      cnt    <= loadVal;
      preCnt <= '0;
    end else if (strb.restartPre) begin
      preCnt <= '0;
    end else if (busTick && (cnt != '0)) begin
      if (preWrap) begin
        preCnt <= '0;
        if (cnt == CNT_W'(1)) cnt <= periodic ? reloadVal : '0;
        else                  cnt <= cnt - CNT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearPend) begin
      pendCnt <= '0;
    end else if (expire && !strb.popPend) begin
      if (pendCnt != PEND_MAX) pendCnt <= pendCnt + PEND_W'(1);
    end else if (strb.popPend && !expire) begin
      pendCnt <= pendCnt - PEND_W'(1);
    end
  end

  assign pendNonZero = (pendCnt != '0);
  assign curRead = (cnt == '0) ? '0 : ((preCnt == '0) ? cnt : cnt - CNT_W'(1));

  // R2: pending expiries are gone right after a restart or disable
  assert_pend_cleared_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearPend |=> (pendCnt == '0));

  // R3: an idle counter only leaves zero through a load
  assert_idle_stays_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((cnt == '0) && !strb.loadInit) |=> (cnt == '0));

  // R6: pending counter moves by at most one per cycle
  assert_pend_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearPend |=> ((pendCnt == $past(pendCnt)) ||
                         (pendCnt == $past(pendCnt) + PEND_W'(1)) ||
                         (pendCnt + PEND_W'(1) == $past(pendCnt))));

endmodule

// File: rtl/lt_timer.sv
module lt_timer
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busTick,
  input  logic        hwEnable,
  input  logic        regWr,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        delivReq,
  output logic [7:0]  delivVector,
  input  logic        delivAck
);

  ltStrobes_t       strb;
  logic [CNT_W-1:0] initVal;
  logic [CNT_W-1:0] curRead;
  logic [2:0]       divShift;
  logic             periodic;
  logic             pendNonZero;

  lt_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .curRead(curRead),
    .pendNonZero(pendNonZero), .hwEnable(hwEnable), .delivAck(delivAck),
    .strb(strb), .initVal(initVal), .divShift(divShift), .periodic(periodic),
    .delivReq(delivReq), .delivVector(delivVector)
  );

  lt_datapath #(.CNT_W(CNT_W), .PEND_W(PEND_W)) uData (
    .clk(clk), .rstN(rstN), .busTick(busTick), .strb(strb),
    .loadVal(regWdata[CNT_W-1:0]), .reloadVal(initVal), .divShift(divShift),
    .periodic(periodic), .curRead(curRead), .pendNonZero(pendNonZero)
  );

endmodule

// File: tb/tb_lt_timer.sv
`timescale 1ns/1ps
module tb_lt_timer;

  localparam int PEND_W = 3;
  localparam int PEND_MAX = (1 << PEND_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busTick = 1'b0, hwEnable = 1'b0, regWr = 1'b0, delivAck = 1'b0;
  logic [3:0] regAddr = 4'h2;
  logic [31:0] regWdata = 32'h0, regRdata;
  logic delivReq;
  logic [7:0] delivVector;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lt_timer #(.CNT_W(32), .PEND_W(PEND_W)) dut (
    .clk(clk), .rstN(rstN), .busTick(busTick), .hwEnable(hwEnable),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .delivReq(delivReq), .delivVector(delivVector), .delivAck(delivAck)
  );

  // ---------------- reference model ----------------
  bit mSwEn = 0;
  logic [31:0] mEntry [6] = '{default: 32'h0001_0000};
  longint mInit = 0, mRem = 0;
  int mCode = 0, mPend = 0;

  function automatic longint divOf(int code);
    return longint'(1) << ((code + 1) % 8);
  endfunction

  function automatic bit mReq();
    return (mPend > 0) && !mEntry[0][16] && mSwEn && hwEnable;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSwEn = 0; mInit = 0; mRem = 0; mCode = 0; mPend = 0;
      for (int i = 0; i < 6; i++) mEntry[i] = 32'h0001_0000;
    end else begin
      bit pop, exp, wInit, wDiv, wOff;
      longint d;
      pop = mReq() && delivAck;
      exp = 0;
      d = divOf(mCode);
      wInit = regWr && regAddr == 4'h1;
      wDiv  = regWr && regAddr == 4'h3;
      wOff  = regWr && regAddr == 4'h0 && !regWdata[0];
      if (wInit) mRem = longint'(regWdata) * d;
      else if (wDiv) begin
        int nc;
        nc = {regWdata[3], regWdata[1], regWdata[0]};
        mRem = ((mRem + d - 1) / d) * divOf(nc);
      end else if (busTick && mRem > 0) begin
        mRem--;
        if (mRem == 0) begin
          exp = 1;
          if (mEntry[0][17]) mRem = mInit * d;
        end
      end
      if (wInit || wOff) mPend = 0;
      else if (exp && !pop) mPend = (mPend < PEND_MAX) ? mPend + 1 : mPend;
      else if (pop && !exp) mPend--;
      if (regWr) begin
        if (regAddr == 4'h1) mInit = regWdata;
        if (regAddr == 4'h3) mCode = {regWdata[3], regWdata[1], regWdata[0]};
        if (regAddr >= 4'h8 && regAddr <= 4'hD) begin
          int k;
          k = regAddr - 4'h8;
          mEntry[k] = (regWdata & ((k == 0) ? 32'h0003_10FF : 32'h0001_00FF))
                      | (mSwEn ? 32'h0 : 32'h0001_0000);
        end
        if (regAddr == 4'h0) begin
          if (!regWdata[0]) for (int i = 0; i < 6; i++) mEntry[i][16] = 1'b1;
          mSwEn = regWdata[0];
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [31:0] e;
      string tag;
      e = 32'h0; tag = "R10";
      case (regAddr)
        4'h0: begin e = {31'h0, mSwEn}; tag = "R7"; end
        4'h1: begin e = mInit[31:0]; tag = "R2"; end
        4'h2: begin e = 32'(mRem / divOf(mCode)); tag = "R4"; end
        4'h3: begin e = {28'h0, 1'(mCode >> 2), 1'b0, 2'(mCode)}; tag = "R1"; end
        default: if (regAddr >= 4'h8 && regAddr <= 4'hD) begin
          e = mEntry[regAddr - 4'h8]; tag = "R8";
        end
      endcase
      chk(tag, regRdata, e);
      chk("R6 req", 32'(delivReq), 32'(mReq()));
      chk("R8 vec", 32'(delivVector), 32'(mEntry[0][7:0]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1 regWr = 1; regAddr = a; regWdata = d;
    @(posedge clk); #1 regWr = 0; regAddr = 4'h2;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1 regAddr = a;
    @(negedge clk); d = regRdata;
  endtask

  task automatic tickN(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 busTick = 1;
    end
    @(posedge clk); #1 busTick = 0;
    @(negedge clk);
  endtask

  task automatic ackPulse();
    @(posedge clk); #1 delivAck = 1;
    @(posedge clk); #1 delivAck = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int acks;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R10 reset state
    rd(4'h8, v); chk("R10 entry0 reset", v, 32'h0001_0000);
    rd(4'hD, v); chk("R10 entry5 reset", v, 32'h0001_0000);
    rd(4'h2, v); chk("R10 cur reset", v, 0);
    rd(4'h0, v); chk("R10 ctrl reset", v, 0);
    hwEnable = 1;
    wr(4'h0, 1);
    wr(4'h8, 32'h0000_0040);
    // R2 / R1: divisor 1, five ticks to expiry
    wr(4'h3, 32'hB); wr(4'h1, 5);
    tickN(4); chk("R2 no early expiry", 32'(delivReq), 0);
    tickN(1); chk("R2 expiry after 5 ticks", 32'(delivReq), 1);
    chk("R8 vector out", 32'(delivVector), 32'h40);
    ackPulse(); chk("R6 ack drains", 32'(delivReq), 0);
    rd(4'h2, v); chk("R4 one-shot reads zero", v, 0);
    // R1 divisor 2
    wr(4'h3, 0); wr(4'h1, 3);
    tickN(1); rd(4'h2, v); chk("R4 floor(5/2)", v, 2);
    tickN(4); chk("R1 not yet at 5 ticks", 32'(delivReq), 0);
    tickN(1); chk("R1 expiry at 6 ticks", 32'(delivReq), 1);
    ackPulse();
    wr(4'h3, 32'h3); rd(4'h3, v); chk("R1 cfg 3 readback", v, 32'h3);
    wr(4'h3, 32'hF); rd(4'h3, v); chk("R1 cfg F readback", v, 32'hB);
    wr(4'h3, 32'h4); rd(4'h3, v); chk("R1 bit2 dropped", v, 32'h0);
    // R5 periodic, random traffic against the model
    wr(4'h8, 32'h0002_0041); wr(4'h3, 32'h1); wr(4'h1, 3);
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      busTick = 1'($urandom % 2);
      delivAck = ($urandom % 3) == 0;
      hwEnable = ($urandom % 8) != 0;
    end
    @(posedge clk); #1 busTick = 0; delivAck = 0; hwEnable = 1;
    tickN(12); chk("R5 periodic still counting", 32'(v != 32'hFFFF_FFFF), 1);
    rd(4'h2, v); chk("R5 reload keeps count nonzero", 32'(v <= 3), 1);
    // R3 zero initial count
    wr(4'h1, 0); tickN(50);
    rd(4'h2, v); chk("R3 cur zero", v, 0);
    chk("R3 no expiry", 32'(delivReq), 0);
    // R6 saturation
    wr(4'h8, 32'h0003_0040); wr(4'h3, 32'hB); wr(4'h1, 1);
    tickN(20); chk("R6 masked no req", 32'(delivReq), 0);
    wr(4'h8, 32'h0002_0040);
    acks = 0;
    while (delivReq && acks < 20) begin ackPulse(); acks++; end
    chk("R6 saturated count", acks, PEND_MAX);
    // R7 software disable
    wr(4'h8, 32'h0003_0040); tickN(3);
    wr(4'h0, 0);
    for (int i = 8; i <= 13; i++) begin
      rd(4'(i), v); chk("R7 mask forced", 32'(v[16]), 1);
    end
    wr(4'h8, 32'h0000_0040); rd(4'h8, v); chk("R7 write while off", v, 32'h0001_0040);
    wr(4'h0, 1); wr(4'h8, 32'h0000_0040);
    chk("R7 pending cleared", 32'(delivReq), 0);
    // R8 field filtering
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, v); chk("R8 timer fields", v, 32'h0003_10FF);
    wr(4'hB, 32'hFFFF_FFFF); rd(4'hB, v); chk("R8 other fields", v, 32'h0001_00FF);
    wr(4'h8, 32'h0001_0040);
    // R9 divide change mid-count
    wr(4'h3, 0); wr(4'h1, 10); tickN(3);
    rd(4'h2, v); chk("R4 floor(17/2)", v, 8);
    wr(4'h3, 32'hB); rd(4'h2, v); chk("R9 rounded up count", v, 9);
    wr(4'h2, 32'h55); rd(4'h2, v); chk("R10 cur write ignored", v, 9);
    rd(4'h5, v); chk("R10 unmapped", v, 0);
    // R2 restart clears pending
    wr(4'h8, 32'h0003_0040); wr(4'h1, 2); tickN(4);
    wr(4'h1, 100); wr(4'h8, 32'h0000_0040);
    chk("R2 restart clears pending", 32'(delivReq), 0);
    rd(4'h2, v); chk("R2 restart value", v, 100);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule